// File: doc/BRIEF.md
# Stream Data Buffer with Fill Threshold

This block is the per-stream staging buffer of a DMA engine. It sits between the peripheral-facing port and the memory-facing port of one stream and holds up to four 32-bit words. Every stream instantiates its own copy. A direction input selects which side produces data and which side consumes it. When `cfg_m2p_i` is 0 (peripheral to memory), data enters on the peripheral port and leaves on the memory port. When it is 1 (memory to peripheral), data enters on the memory port and leaves on the peripheral port.

In buffered mode, words accumulate in the buffer. The memory-side request `mem_req_o` rises once the amount of data (peripheral to memory) or free room (memory to peripheral) reaches a programmable fraction of the buffer. In direct mode, the buffer shrinks to a single slot. Each peripheral access is then matched by one memory transfer. In the memory-to-peripheral direction, that slot is kept preloaded so the peripheral never waits. Accesses that would overflow or underflow are dropped and flagged. Switching the mode or the direction empties the buffer.

Top module: `strm_buf`

## Requirements
- R1: After reset, `level_o` is 0, `empty_o` is 1, `full_o` is 0, `err_o` is 0, and buffered peripheral-to-memory mode (`cfg_direct_i`=0, `cfg_m2p_i`=0) is in effect.
- R2: In buffered mode (`cfg_direct_i`=0), the buffer holds four words and returns them oldest first. `level_o` counts the stored words. `full_o` is 1 at four words and `empty_o` is 1 at zero words. Both flags and the level are updated on the clock edge that accepts an access.
- R3: With `cfg_m2p_i`=0, writes are taken from `per_wr_i`/`per_wdata_i` and reads from `mem_rd_i`. With `cfg_m2p_i`=1, writes are taken from `mem_wr_i`/`mem_wdata_i` and reads from `per_rd_i`. Strobes on the other side change neither the level nor `err_o`.
- R4: `cfg_thresh_i` sets the threshold in words: code 00 gives 1, 01 gives 2, 10 gives 3, and 11 gives 4. The threshold takes effect combinationally.
- R5: In buffered peripheral-to-memory mode, `mem_req_o` is 1 exactly when `level_o` is greater than or equal to the threshold.
- R6: In buffered memory-to-peripheral mode, `mem_req_o` is 1 exactly when the free room (4 − `level_o`) is greater than or equal to the threshold.
- R7: In direct mode (`cfg_direct_i`=1), the capacity is one word and `cfg_thresh_i` has no effect. In peripheral-to-memory direction, `mem_req_o` is 1 exactly when that word is present, and a second peripheral write is refused.
- R8: In direct memory-to-peripheral mode, `mem_req_o` is 1 while the slot is empty, so exactly one word is preloaded. A further memory write is refused. The peripheral reads the preloaded word with no wait, after which `mem_req_o` rises again.
- R9: A write while full or a read while empty is ignored. `err_o` is 1 for exactly the one cycle after the clock edge that saw the ignored access.
- R10: A change of `cfg_direct_i` or `cfg_m2p_i` empties the buffer on the next clock edge and raises no error. A change of `cfg_thresh_i` alone keeps the stored data.
- R11: `per_rdata_o` and `mem_rdata_o` show the oldest stored word whenever the buffer is not empty, before the read strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_direct_i | input | 1 | 1 = direct (single slot) mode, 0 = buffered mode |
| cfg_m2p_i | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| cfg_thresh_i | input | 2 | Threshold code (00 quarter, 01 half, 10 three quarters, 11 full) |
| per_wr_i | input | 1 | Peripheral-side write strobe |
| per_wdata_i | input | 32 | Peripheral-side write data |
| per_rd_i | input | 1 | Peripheral-side read strobe |
| per_rdata_o | output | 32 | Oldest stored word for the peripheral side |
| mem_wr_i | input | 1 | Memory-side write strobe |
| mem_wdata_i | input | 32 | Memory-side write data |
| mem_rd_i | input | 1 | Memory-side read strobe |
| mem_rdata_o | output | 32 | Oldest stored word for the memory side |
| mem_req_o | output | 1 | Request for a memory-side transfer |
| level_o | output | 3 | Number of stored words |
| full_o | output | 1 | Buffer at capacity for the current mode |
| empty_o | output | 1 | No word stored |
| err_o | output | 1 | One-cycle pulse after an ignored write or read |

## Verification
Several invariants are checked on every cycle by assertions:
- the level never exceeds the capacity of the current mode;
- direct mode never holds more than one word;
- a full buffer never grows and an empty one never shrinks;
- a mode or direction change leaves the buffer empty;
- the request is present whenever the direct memory-to-peripheral slot is empty.

Other behaviours can only be shown by the bench's scenarios:
- first-in first-out data order;
- the mapping of each threshold code onto the request in both directions;
- the routing of strobes by direction;
- the preload-then-serve sequence of direct mode;
- a threshold change that keeps the stored data.

// File: rtl/strm_buf_pkg.sv
package strm_buf_pkg;

  // Threshold select encoding, in fractions of the buffer depth
  typedef enum logic [1:0] {
    TH_QUARTER = 2'b00,
    TH_HALF    = 2'b01,
    TH_3QUART  = 2'b10,
    TH_WHOLE   = 2'b11
  } thresh_e;

endpackage

// File: rtl/strm_buf_rst_sync.sv
module strm_buf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/strm_buf_mem.sv
module strm_buf_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic              hit;
    logic [DATA_W-1:0] word_q;

    assign hit = wr_en && (wr_ptr == PTR_W'(g));

    // data storage: no reset needed, validity tracked by the level counter
    always_ff @(posedge clk) begin
      if (hit) word_q <= wr_data;
    end

    assign ent_w[g] = word_q;
  end

  assign rd_data = ent_w[rd_ptr];

endmodule

// File: rtl/strm_buf_ctrl.sv
module strm_buf_ctrl #(
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             direct_i,
  input  logic             m2p_i,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic             wr_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] cap,
  output logic             full,
  output logic             empty,
  output logic             err,
  output logic             direct_q,
  output logic             m2p_q
);

  logic [LVL_W-1:0] level_q, level_n;
  logic [PTR_W-1:0] wp_q, wp_n, rp_q, rp_n;
  logic             err_q, err_n;
  logic             chg, rd_ok, upd;

  assign chg   = (direct_i != direct_q) || (m2p_i != m2p_q);
  assign cap   = direct_q ? LVL_W'(1) : LVL_W'(DEPTH);
  assign full  = (level_q == cap);
  assign empty = (level_q == '0);
  assign wr_ok = wr_req && !full  && !chg;
  assign rd_ok = rd_req && !empty && !chg;
  assign upd   = chg || wr_ok || rd_ok;

  always_comb begin
    level_n = level_q;
    wp_n    = wp_q;
    rp_n    = rp_q;
    err_n   = 1'b0;
    if (chg) begin
      level_n = '0;
      wp_n    = '0;
      rp_n    = '0;
    end else begin
      if (wr_ok) wp_n = wp_q + 1'b1;
      if (rd_ok) rp_n = rp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level_n = level_q + 1'b1;
        2'b01:   level_n = level_q - 1'b1;
        default: level_n = level_q;
      endcase
      err_n = (wr_req && full) || (rd_req && empty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      wp_q     <= '0;
      rp_q     <= '0;
      err_q    <= 1'b0;
      direct_q <= 1'b0;
      m2p_q    <= 1'b0;
    end else begin
      err_q    <= err_n;
      direct_q <= direct_i;
      m2p_q    <= m2p_i;
      if (upd) begin
        level_q <= level_n;
        wp_q    <= wp_n;
        rp_q    <= rp_n;
      end
    end
  end

  assign level  = level_q;
  assign wr_ptr = wp_q;
  assign rd_ptr = rp_q;
  assign err    = err_q;

  // R2: never more words than the mode allows
  a_r2_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= cap);

  // R7: direct mode keeps at most a single word
  a_r7_direct_single: assert property (@(posedge clk) disable iff (!rst_n)
    direct_q |-> (level_q <= LVL_W'(1)));

  // R9: a full buffer cannot grow
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !chg) |=> (level_q <= $past(level_q)));

  // R9: an empty buffer cannot shrink
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !chg) |=> (level_q >= $past(level_q)));

  // R10: a configuration change leaves it empty with no error
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (level_q == '0 && !err_q));

endmodule

// File: rtl/strm_buf_req.sv
module strm_buf_req
  import strm_buf_pkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       thresh_i,
  input  logic             direct_q,
  input  logic             m2p_q,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] cap,
  output logic             mem_req
);

  localparam logic [LVL_W-1:0] TH_Q1 = LVL_W'(DEPTH / 4);
  localparam logic [LVL_W-1:0] TH_Q2 = LVL_W'(DEPTH / 2);
  localparam logic [LVL_W-1:0] TH_Q3 = LVL_W'((3 * DEPTH) / 4);
  localparam logic [LVL_W-1:0] TH_Q4 = LVL_W'(DEPTH);

  logic [LVL_W-1:0] th_sel, th_eff, room;

  always_comb begin
    case (thresh_i)
      TH_QUARTER: th_sel = TH_Q1;
      TH_HALF:    th_sel = TH_Q2;
      TH_3QUART:  th_sel = TH_Q3;
      default:    th_sel = TH_Q4;
    endcase
  end

  // direct mode: one-word granule regardless of the programmed threshold
  assign th_eff  = direct_q ? LVL_W'(1) : th_sel;
  assign room    = cap - level;
  assign mem_req = m2p_q ? (room >= th_eff) : (level >= th_eff);

  // R8: an empty direct memory-to-peripheral slot always asks for its preload
  a_r8_preload_req: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q && m2p_q && level == '0) |-> mem_req);

  // R5: a full buffer draining to memory always requests
  a_r5_full_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (!m2p_q && level == cap) |-> mem_req);

endmodule

// File: rtl/strm_buf.sv
module strm_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cfg_direct_i,
  input  logic              cfg_m2p_i,
  input  logic [1:0]        cfg_thresh_i,
  input  logic              per_wr_i,
  input  logic [DATA_W-1:0] per_wdata_i,
  input  logic              per_rd_i,
  output logic [DATA_W-1:0] per_rdata_o,
  input  logic              mem_wr_i,
  input  logic [DATA_W-1:0] mem_wdata_i,
  input  logic              mem_rd_i,
  output logic [DATA_W-1:0] mem_rdata_o,
  output logic              mem_req_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              err_o
);

  logic              rst_n;
  logic              wr_req, rd_req, wr_ok;
  logic [DATA_W-1:0] wr_data, head;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  level, cap;
  logic              direct_q, m2p_q;

  strm_buf_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  // side routing by direction: producer writes, consumer reads
  assign wr_req  = m2p_q ? mem_wr_i    : per_wr_i;
  assign wr_data = m2p_q ? mem_wdata_i : per_wdata_i;
  assign rd_req  = m2p_q ? per_rd_i    : mem_rd_i;

  strm_buf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .direct_i (cfg_direct_i),
    .m2p_i    (cfg_m2p_i),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .wr_ok    (wr_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (level),
    .cap      (cap),
    .full     (full_o),
    .empty    (empty_o),
    .err      (err_o),
    .direct_q (direct_q),
    .m2p_q    (m2p_q)
  );

  strm_buf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .rd_ptr  (rd_ptr),
    .rd_data (head)
  );

  strm_buf_req #(.DEPTH(DEPTH)) u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .thresh_i (cfg_thresh_i),
    .direct_q (direct_q),
    .m2p_q    (m2p_q),
    .level    (level),
    .cap      (cap),
    .mem_req  (mem_req_o)
  );

  assign per_rdata_o = head;
  assign mem_rdata_o = head;
  assign level_o     = level;

endmodule

// File: tb/strm_buf_tb_top.sv
module strm_buf_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        arst_n;
  logic        mdirect, mdir;
  logic [1:0]  mth;
  logic        per_wr, per_rd, mem_wr, mem_rd;
  logic [31:0] per_wdata, mem_wdata;
  logic [31:0] per_rdata, mem_rdata;
  logic        mem_req, full_o, empty_o, err_o;
  logic [2:0]  level_o;

  int          total, bad;
  int          mlvl;
  logic [31:0] q [$];
  bit          rd_expect;

  strm_buf dut_i (
    .clk          (clk),
    .arst_n       (arst_n),
    .cfg_direct_i (mdirect),
    .cfg_m2p_i    (mdir),
    .cfg_thresh_i (mth),
    .per_wr_i     (per_wr),
    .per_wdata_i  (per_wdata),
    .per_rd_i     (per_rd),
    .per_rdata_o  (per_rdata),
    .mem_wr_i     (mem_wr),
    .mem_wdata_i  (mem_wdata),
    .mem_rd_i     (mem_rd),
    .mem_rdata_o  (mem_rdata),
    .mem_req_o    (mem_req),
    .level_o      (level_o),
    .full_o       (full_o),
    .empty_o      (empty_o),
    .err_o        (err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic int mcap();
    return mdirect ? 1 : 4;
  endfunction

  task automatic chk_req(input string tag);
    int th;
    bit exp;
    th  = mdirect ? 1 : (int'(mth) + 1);
    exp = mdir ? ((mcap() - mlvl) >= th) : (mlvl >= th);
    chk(tag, mem_req, exp);
  endtask

  task automatic chk_flags(input string tag);
    chk(tag, level_o, mlvl);
    chk(tag, full_o, mlvl == mcap());
    chk(tag, empty_o, mlvl == 0);
  endtask

  // driver: a write on one side; accepted words go to the scoreboard
  task automatic do_wr(input bit on_mem, input logic [31:0] d);
    bit right, ok;
    right = (on_mem == mdir);
    ok    = right && (mlvl < mcap());
    if (on_mem) begin mem_wr = 1'b1; mem_wdata = d; end
    else        begin per_wr = 1'b1; per_wdata = d; end
    cyc();
    mem_wr = 1'b0;
    per_wr = 1'b0;
    if (ok) begin q.push_back(d); mlvl++; end
    if (right) chk("R9 write error flag", err_o, !ok);
    else       chk("R3 wrong-side write no error", err_o, 1'b0);
    chk_flags("R2 R3 flags after write");
  endtask

  // driver: a read on one side; the monitor compares the data
  task automatic do_rd(input bit on_mem);
    bit right, ok;
    right = (on_mem != mdir);
    ok    = right && (mlvl > 0);
    rd_expect = ok;
    if (on_mem) mem_rd = 1'b1;
    else        per_rd = 1'b1;
    cyc();
    mem_rd = 1'b0;
    per_rd = 1'b0;
    rd_expect = 1'b0;
    if (ok) mlvl--;
    if (right) chk("R9 read error flag", err_o, !ok);
    else       chk("R3 wrong-side read no error", err_o, 1'b0);
    chk_flags("R2 R3 flags after read");
  endtask

  task automatic idle();
    cyc();
    chk("R9 error pulse lasts one cycle", err_o, 1'b0);
  endtask

  task automatic set_cfg(input bit dr, input bit m2p);
    mdirect = dr;
    mdir    = m2p;
    cyc();
    mlvl = 0;
    q.delete();
    chk("R10 no error on flush", err_o, 1'b0);
    chk_flags("R10 flushed after config change");
  endtask

  // monitor: compare the head word with the scoreboard before each read edge
  always @(negedge clk) begin
    if (rd_expect) begin
      if (q.size() == 0) begin
        chk("R2 scoreboard underrun", 32'd1, 32'd0);
      end else begin
        logic [31:0] exp_w;
        exp_w = q.pop_front();
        chk("R2 R11 read data order", mdir ? per_rdata : mem_rdata, exp_w);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; mlvl = 0; rd_expect = 1'b0;
    arst_n = 1'b0;
    mdirect = 1'b0; mdir = 1'b0; mth = 2'b00;
    per_wr = 1'b0; per_rd = 1'b0; mem_wr = 1'b0; mem_rd = 1'b0;
    per_wdata = '0; mem_wdata = '0;
    repeat (3) @(posedge clk);
    #3 arst_n = 1'b1;
    repeat (3) cyc();

    // R1 reset state
    chk("R1 level", level_o, 0);
    chk("R1 empty", empty_o, 1'b1);
    chk("R1 full", full_o, 1'b0);
    chk("R1 err", err_o, 1'b0);
    chk_req("R1 R5 no request when empty");

    // buffered, peripheral to memory, threshold half
    mth = 2'b01;
    #1 chk_req("R5 half threshold at level 0");
    for (int i = 0; i < 4; i++) begin
      do_wr(1'b0, 32'hA000_0010 + i);
      chk_req("R5 request against level");
      for (int c = 0; c < 4; c++) begin
        mth = 2'(c);
        #1 chk_req("R4 threshold code sweep p2m");
      end
      mth = 2'b01;
      #1;
    end
    do_wr(1'b0, 32'hDEAD_0001);           // R9 overflow
    idle();
    do_wr(1'b1, 32'hDEAD_0002);           // R3 wrong side
    do_rd(1'b0);                          // R3 wrong side
    for (int i = 0; i < 4; i++) do_rd(1'b1);
    do_rd(1'b1);                          // R9 underflow
    idle();

    // R10 direction change flushes stored data
    do_wr(1'b0, 32'h1111_0001);
    do_wr(1'b0, 32'h1111_0002);
    set_cfg(1'b0, 1'b1);

    // buffered memory to peripheral, threshold three quarters
    mth = 2'b10;
    #1 chk_req("R6 room threshold at level 0");
    for (int i = 0; i < 3; i++) begin
      do_wr(1'b1, 32'hB000_0020 + i);
      chk_req("R6 request against room");
      for (int c = 0; c < 4; c++) begin
        mth = 2'(c);
        #1 chk_req("R4 threshold code sweep m2p");
      end
      mth = 2'b10;
      #1;
    end
    mth = 2'b00;
    cyc();
    chk("R10 threshold change keeps data", level_o, 3);
    chk_req("R6 room threshold quarter");
    for (int i = 0; i < 3; i++) do_rd(1'b0);
    chk_req("R6 request when empty");

    // direct memory to peripheral: single preload
    set_cfg(1'b1, 1'b1);
    mth = 2'b11;
    #1 chk_req("R8 preload request while empty");
    do_wr(1'b1, 32'hC000_0030);
    chk_req("R8 request drops after preload");
    do_wr(1'b1, 32'hC000_0031);           // R8 second word refused
    do_rd(1'b0);
    chk_req("R8 request returns after peripheral read");

    // direct peripheral to memory
    set_cfg(1'b1, 1'b0);
    chk_req("R7 no request when empty");
    do_wr(1'b0, 32'hD000_0040);
    chk_req("R7 request with one word");
    mth = 2'b10;
    #1 chk_req("R7 threshold code has no effect");
    do_wr(1'b0, 32'hD000_0041);           // R7 second word refused
    do_rd(1'b1);
    chk_req("R7 request drops after memory read");

    // R10 mode change flushes too
    do_wr(1'b0, 32'hE000_0050);
    set_cfg(1'b0, 1'b0);
    do_wr(1'b0, 32'hE000_0051);
    do_rd(1'b1);
    idle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule